// File: doc/BRIEF.md
# Fly-by SDRAM Write Sequencer

This block sequences single-beat writes into an SDRAM whose data can come from either of two places. On an ordinary write the controller side drives the data bus. On a fly-by write, an external peripheral puts its word directly on the memory data bus. The sequencer then supplies only the command, bank and address timing, and keeps its own bus drivers off. A request arrives through a ready/valid handshake. It carries a bank, row, column and a fly-by flag, and a 2-bit lead setting is sampled with it.

For each bank the sequencer tracks whether a row is open, which row it is, and whether that row was opened for fly-by use. A request that matches all three goes straight to the write command. A request to a closed bank starts with an activate. If the bank is open but the row or the mode differs, the row is precharged and then activated again.

During fly-by writes, three active-low strobes give the peripheral its timing:
- An access strobe warns that a fly-by access is pending.
- A direction strobe, held low, marks the access as a write.
- A transfer strobe falls a programmed number of cycles before the write command, which is the cycle the memory latches data.

Top module: `flyby_wr_seq`

## Requirements
- R1: While reset is applied and afterwards with no request, the outputs rest as follows: `req_ready`=1, `{sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}`=4'b1111, `sd_ba`=0, `sd_a`=0, `dq_oe`=0, and all three fly-by strobes high.
- R2: Command encodings on `{cs_n,ras_n,cas_n,we_n}`:
  - activate is 0011, with the row on `sd_a`;
  - write is 0100, with the column zero-extended on `sd_a`, so bit 10 is 0 (no auto-precharge);
  - precharge is 0010, with `sd_a`=0 (single bank);
  - every other cycle is 1111, with `sd_ba` and `sd_a` at 0.
  
  `sd_ba` carries the request bank in each command cycle.
- R3: A request to a bank with no open row issues activate in the first cycle after acceptance. The write follows exactly T_RCD cycles later for an ordinary write, and max(T_RCD, WL) cycles later for a fly-by write.
- R4: A request whose bank has the same row open, in the same mode (fly-by or ordinary), issues no precharge or activate. An ordinary write issues the write command in the first cycle after acceptance. A fly-by write issues it WL cycles after that first cycle.
- R5: A request to an open bank whose open row or mode differs issues precharge in the first cycle after acceptance, activate T_RP cycles later, and then proceeds as in R3. The bank then records the new row and mode.
- R6: On an ordinary write, `dq_oe` is 1 exactly in the write command cycle. On a fly-by write, `dq_oe` stays 0 for the whole sequence.
- R7: On a fly-by write, `fb_acc_n` and `fb_dir_n` are low from the activate cycle through the write cycle. On a row hit they are low from the first cycle after acceptance through the write cycle. They are high in the cycle after the write. Ordinary writes leave them high.
- R8: On a fly-by write, `fb_xfer_n` is low from WL cycles before the write command through the write command, and high otherwise. WL is `wl` sampled at acceptance, from 0 to 3.
- R9: `req_ready` is 0 from the cycle after acceptance through the write cycle. A request held valid while busy is taken only once `req_ready` returns, and no command is issued while `req_ready` is 1.
- R10: The request fields and `wl` are sampled only at acceptance. Changing them, or driving them while `req_valid` is 0, has no effect on the sequence.
- R11: Each bank's open-row state is independent: an access to one bank never closes or changes another bank's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all strobes are timed against it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_flyby | input | 1 | 1 selects a fly-by write |
| req_bank | input | BA_W (2) | Destination bank |
| req_row | input | ROW_W (12) | Destination row |
| req_col | input | COL_W (9) | Destination column |
| wl | input | WL_W (2) | Transfer-strobe lead in cycles |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BA_W (2) | SDRAM bank address |
| sd_a | output | ROW_W (12) | SDRAM address bus |
| dq_oe | output | 1 | Drive enable for the controller's data bus drivers |
| fb_acc_n | output | 1 | Fly-by access warning, active low |
| fb_dir_n | output | 1 | Fly-by direction, low for write |
| fb_xfer_n | output | 1 | Fly-by transfer strobe, active low |

## Verification
The requests walk every bank state through each path:
- a closed bank;
- a same-row hit in the same mode;
- a row miss;
- a mode-only mismatch in both directions.

This separates the activate-only, write-only and precharge-activate paths, and shows whether the mode bit is really compared. Fly-by writes are repeated for every WL from 0 to 3, on both hits and activates, so that the case where WL exceeds T_RCD, and the extra wait it causes, is told apart from the case where the activate delay dominates. Back-to-back requests, and noise driven on the request fields while not valid, show that the handshake stalls and that only the sampled values are used.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_TRP  = 3'd2,
    ST_ACT  = 3'd3,
    ST_GAP  = 3'd4,
    ST_WR   = 3'd5
  } seq_state_e;

endpackage

// File: rtl/fbw_rst_sync.sv
module fbw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fbw_bank_track.sv
module fbw_bank_track #(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  localparam int BA_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BA_W-1:0]  look_bank,
  input  logic [ROW_W-1:0] look_row,
  input  logic             look_fb,
  output logic             look_open,
  output logic             look_hit,
  input  logic             upd_act,
  input  logic             upd_pre,
  input  logic [BA_W-1:0]  upd_bank,
  input  logic [ROW_W-1:0] upd_row,
  input  logic             upd_fb
);

  logic [BANKS-1:0] open_v;
  logic [BANKS-1:0] hit_v;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             fb_q;
    logic             sel;
    logic             act_en;

    assign sel    = (upd_bank == BA_W'(b));
    assign act_en = upd_act && sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
      end else if (act_en) begin
        open_q <= 1'b1;
      end else if (upd_pre && sel) begin
        open_q <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
        fb_q  <= 1'b0;
      end else if (act_en) begin
        row_q <= upd_row;
        fb_q  <= upd_fb;
      end
    end

    assign open_v[b] = open_q;
    assign hit_v[b]  = open_q && (row_q == look_row) && (fb_q == look_fb);
  end

  assign look_open = open_v[look_bank];
  assign look_hit  = hit_v[look_bank];

  AST_ACT_ON_CLOSED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_act |-> !open_v[upd_bank]); // R5

  AST_PRE_ON_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pre |-> open_v[upd_bank]); // R5

endmodule

// File: rtl/fbw_seq_ctrl.sv
module fbw_seq_ctrl
  import fbw_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int WL_W  = 2,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_flyby,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [WL_W-1:0]  wl,
  input  logic             look_open,
  input  logic             look_hit,
  output logic             req_ready,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [BA_W-1:0]  lat_bank,
  output logic [ROW_W-1:0] lat_row,
  output logic [COL_W-1:0] lat_col,
  output logic             lat_fb,
  output logic [WL_W-1:0]  lat_wl,
  output logic             upd_act,
  output logic             upd_pre
);

  localparam logic [CNT_W-1:0] TRP_LOAD = (T_RP > 1) ? CNT_W'(T_RP - 2) : '0;
  localparam logic [CNT_W-1:0] RCD_VAL  = CNT_W'(T_RCD);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;
  logic [CNT_W-1:0] wl_req_ext;
  logic [CNT_W-1:0] wl_lat_ext;
  logic [CNT_W-1:0] gap;

  assign accept     = req_valid && (state_q == ST_IDLE);
  assign wl_req_ext = CNT_W'(wl);
  assign wl_lat_ext = CNT_W'(lat_wl);
  assign gap        = (lat_fb && (wl_lat_ext > RCD_VAL)) ? wl_lat_ext : RCD_VAL;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (look_hit) begin
            if (req_flyby && (wl != '0)) begin
              state_d = ST_GAP;
              cnt_d   = wl_req_ext - CNT_W'(1);
            end else begin
              state_d = ST_WR;
            end
          end else if (look_open) begin
            state_d = ST_PRE;
          end else begin
            state_d = ST_ACT;
          end
        end
      end
      ST_PRE: begin
        if (T_RP > 1) begin
          state_d = ST_TRP;
          cnt_d   = TRP_LOAD;
        end else begin
          state_d = ST_ACT;
        end
      end
      ST_TRP: begin
        if (cnt_q == '0) state_d = ST_ACT;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      ST_ACT: begin
        if (gap > CNT_W'(1)) begin
          state_d = ST_GAP;
          cnt_d   = gap - CNT_W'(2);
        end else begin
          state_d = ST_WR;
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) state_d = ST_WR;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      ST_WR:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_bank <= '0;
      lat_row  <= '0;
      lat_col  <= '0;
      lat_fb   <= 1'b0;
      lat_wl   <= '0;
    end else if (accept) begin
      lat_bank <= req_bank;
      lat_row  <= req_row;
      lat_col  <= req_col;
      lat_fb   <= req_flyby;
      lat_wl   <= wl;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign upd_act   = (state_q == ST_ACT);
  assign upd_pre   = (state_q == ST_PRE);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R9

  AST_ACT_FOLLOWS_PRE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |=> (state_q == ST_TRP || state_q == ST_ACT)); // R5

endmodule

// File: rtl/fbw_pin_drive.sv
module fbw_pin_drive
  import fbw_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int WL_W  = 2,
  parameter int T_RCD = 2,
  parameter int CNT_W = 2
) (
  input  seq_state_e       state,
  input  logic [CNT_W-1:0] cnt,
  input  logic [BA_W-1:0]  lat_bank,
  input  logic [ROW_W-1:0] lat_row,
  input  logic [COL_W-1:0] lat_col,
  input  logic             lat_fb,
  input  logic [WL_W-1:0]  lat_wl,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_a,
  output logic             dq_oe,
  output logic             fb_acc_n,
  output logic             fb_dir_n,
  output logic             fb_xfer_n
);

  logic [CNT_W-1:0] wl_ext;
  logic             lead_in_act;
  logic             lead_in_gap;
  logic             fb_window;

  assign wl_ext      = CNT_W'(lat_wl);
  assign lead_in_act = (state == ST_ACT) && (wl_ext >= CNT_W'(T_RCD));
  assign lead_in_gap = (state == ST_GAP) && (cnt < wl_ext);
  assign fb_window   = (state == ST_ACT) || (state == ST_GAP) || (state == ST_WR);

  always_comb begin
    sd_cs_n  = 1'b1;
    sd_ras_n = 1'b1;
    sd_cas_n = 1'b1;
    sd_we_n  = 1'b1;
    sd_ba    = '0;
    sd_a     = '0;
    dq_oe    = 1'b0;
    case (state)
      ST_ACT: begin
        sd_cs_n  = 1'b0;
        sd_ras_n = 1'b0;
        sd_ba    = lat_bank;
        sd_a     = lat_row;
      end
      ST_WR: begin
        sd_cs_n  = 1'b0;
        sd_cas_n = 1'b0;
        sd_we_n  = 1'b0;
        sd_ba    = lat_bank;
        sd_a     = ROW_W'(lat_col);
        dq_oe    = !lat_fb;
      end
      ST_PRE: begin
        sd_cs_n  = 1'b0;
        sd_ras_n = 1'b0;
        sd_we_n  = 1'b0;
        sd_ba    = lat_bank;
      end
      default: ;
    endcase
  end

  assign fb_acc_n  = !(lat_fb && fb_window);
  assign fb_dir_n  = !(lat_fb && fb_window);
  assign fb_xfer_n = !(lat_fb && ((state == ST_WR) || lead_in_gap || lead_in_act));

endmodule

// File: rtl/flyby_wr_seq.sv
module flyby_wr_seq
  import fbw_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int WL_W  = 2,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  localparam int BA_W    = $clog2(BANKS),
  localparam int WL_MAX  = (1 << WL_W) - 1,
  localparam int DLY_MAX = (T_RCD > T_RP) ? T_RCD : T_RP,
  localparam int CNT_MAX = (DLY_MAX > WL_MAX) ? DLY_MAX : WL_MAX,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_flyby,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [WL_W-1:0]  wl,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_a,
  output logic             dq_oe,
  output logic             fb_acc_n,
  output logic             fb_dir_n,
  output logic             fb_xfer_n
);

  logic             rst_i_n;
  logic             look_open, look_hit;
  logic             upd_act, upd_pre;
  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [BA_W-1:0]  lat_bank;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  logic             lat_fb;
  logic [WL_W-1:0]  lat_wl;

  fbw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  fbw_bank_track #(.BANKS(BANKS), .ROW_W(ROW_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .look_bank (req_bank),
    .look_row  (req_row),
    .look_fb   (req_flyby),
    .look_open (look_open),
    .look_hit  (look_hit),
    .upd_act   (upd_act),
    .upd_pre   (upd_pre),
    .upd_bank  (lat_bank),
    .upd_row   (lat_row),
    .upd_fb    (lat_fb)
  );

  fbw_seq_ctrl #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .WL_W(WL_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .req_flyby (req_flyby),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .wl        (wl),
    .look_open (look_open),
    .look_hit  (look_hit),
    .req_ready (req_ready),
    .state_o   (state),
    .cnt_o     (cnt),
    .lat_bank  (lat_bank),
    .lat_row   (lat_row),
    .lat_col   (lat_col),
    .lat_fb    (lat_fb),
    .lat_wl    (lat_wl),
    .upd_act   (upd_act),
    .upd_pre   (upd_pre)
  );

  fbw_pin_drive #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .WL_W(WL_W),
    .T_RCD(T_RCD), .CNT_W(CNT_W)
  ) u_pins (
    .state     (state),
    .cnt       (cnt),
    .lat_bank  (lat_bank),
    .lat_row   (lat_row),
    .lat_col   (lat_col),
    .lat_fb    (lat_fb),
    .lat_wl    (lat_wl),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_a      (sd_a),
    .dq_oe     (dq_oe),
    .fb_acc_n  (fb_acc_n),
    .fb_dir_n  (fb_dir_n),
    .fb_xfer_n (fb_xfer_n)
  );

  AST_FLYBY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    !fb_acc_n |-> !dq_oe); // R6

  AST_XFER_HELD_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!fb_xfer_n && sd_we_n) |=> !fb_xfer_n); // R8

  AST_RELEASE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sd_cs_n && !sd_cas_n) |=> (fb_acc_n && fb_xfer_n && req_ready)); // R7

  AST_NO_CMD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_ready |-> sd_cs_n); // R9

endmodule

// File: tb/sim_flyby_wr_seq.sv
module sim_flyby_wr_seq;

  localparam int BANKS = 4;
  localparam int ROW_W = 12;
  localparam int COL_W = 9;
  localparam int WL_W  = 2;
  localparam int T_RCD = 2;
  localparam int T_RP  = 2;
  localparam int BA_W  = 2;
  localparam int VW    = 1 + 4 + BA_W + ROW_W + 1 + 3;

  localparam int C_NONE = 0;
  localparam int C_ACT  = 1;
  localparam int C_WR   = 2;
  localparam int C_PRE  = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic             req_flyby;
  logic [BA_W-1:0]  req_bank;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [WL_W-1:0]  wl;
  logic             sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BA_W-1:0]  sd_ba;
  logic [ROW_W-1:0] sd_a;
  logic             dq_oe, fb_acc_n, fb_dir_n, fb_xfer_n;

  always #5 clk = ~clk;

  flyby_wr_seq #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .WL_W(WL_W),
    .T_RCD(T_RCD), .T_RP(T_RP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_flyby(req_flyby), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .wl(wl), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
    .dq_oe(dq_oe), .fb_acc_n(fb_acc_n), .fb_dir_n(fb_dir_n), .fb_xfer_n(fb_xfer_n)
  );

  typedef struct {
    int bank;
    int row;
    int col;
    bit fb;
    int lead;
  } req_t;

  req_t            rq[$];
  logic [VW-1:0]   exp_q[$];
  bit              m_open[BANKS];
  int              m_row[BANKS];
  bit              m_fb[BANKS];
  int              nvec = 0;
  int              nbad = 0;
  bit              running = 1'b0;
  string           cur_req = "R1";
  int              wl_noise = 0;

  function automatic logic [VW-1:0] mk(bit rdy, int cmd, int ba, int addr,
                                       bit oe, bit acc_lo, bit xf_lo);
    logic [3:0] c;
    logic [BA_W-1:0] b;
    logic [ROW_W-1:0] a;
    case (cmd)
      C_ACT:   c = 4'b0011;
      C_WR:    c = 4'b0100;
      C_PRE:   c = 4'b0010;
      default: c = 4'b1111;
    endcase
    b = (cmd == C_NONE) ? '0 : BA_W'(ba);
    a = (cmd == C_ACT || cmd == C_WR) ? ROW_W'(addr) : '0;
    return {rdy, c, b, a, oe, !acc_lo, !acc_lo, !xf_lo};
  endfunction

  function automatic logic [VW-1:0] idle_vec();
    return mk(1'b1, C_NONE, 0, 0, 1'b0, 1'b0, 1'b0);
  endfunction

  // Behavioural schedule of one accepted request
  task automatic build(req_t r);
    int  cmds[$];
    bit  hit;
    int  act_i;
    int  wr_i;
    int  gap;
    hit   = m_open[r.bank] && (m_row[r.bank] == r.row) && (m_fb[r.bank] == r.fb);
    act_i = 0;
    if (!hit) begin
      if (m_open[r.bank]) begin
        cmds.push_back(C_PRE);
        repeat (T_RP - 1) cmds.push_back(C_NONE);
      end
      act_i = cmds.size();
      cmds.push_back(C_ACT);
      gap = (r.fb && r.lead > T_RCD) ? r.lead : T_RCD;
      repeat (gap - 1) cmds.push_back(C_NONE);
      m_open[r.bank] = 1'b1;
      m_row[r.bank]  = r.row;
      m_fb[r.bank]   = r.fb;
    end else if (r.fb) begin
      repeat (r.lead) cmds.push_back(C_NONE);
    end
    cmds.push_back(C_WR);
    wr_i = cmds.size() - 1;
    for (int i = 0; i <= wr_i; i++) begin
      int addr;
      addr = (cmds[i] == C_ACT) ? r.row : r.col;
      exp_q.push_back(mk(1'b0, cmds[i], r.bank, addr,
                         (cmds[i] == C_WR) && !r.fb,
                         r.fb && (i >= act_i),
                         r.fb && ((wr_i - i) <= r.lead)));
    end
  endtask

  function automatic logic [VW-1:0] got_vec();
    return {req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a,
            dq_oe, fb_acc_n, fb_dir_n, fb_xfer_n};
  endfunction

  task automatic compare(logic [VW-1:0] e, string tag);
    logic [VW-1:0] g;
    g = got_vec();
    nvec++;
    if (g !== e) begin
      nbad++;
      $display("FAIL %s t=%0t got ready=%b cmd=%b ba=%0d a=%h oe=%b acc/dir/xfer=%b exp ready=%b cmd=%b ba=%0d a=%h oe=%b acc/dir/xfer=%b",
               tag, $time, g[VW-1], g[VW-2:VW-5], g[VW-6:VW-7], g[ROW_W+3:4], g[3], g[2:0],
               e[VW-1], e[VW-2:VW-5], e[VW-6:VW-7], e[ROW_W+3:4], e[3], e[2:0]);
    end
  endtask

  // Per-cycle comparison and request driving (R9, R10: noise while not valid)
  always @(negedge clk) begin
    if (running) begin
      bit idle_now;
      logic [VW-1:0] e;
      idle_now = (exp_q.size() == 0);
      e = idle_now ? idle_vec() : exp_q.pop_front();
      compare(e, cur_req);
      if (rq.size() > 0) begin
        req_valid = 1'b1;
        req_bank  = BA_W'(rq[0].bank);
        req_row   = ROW_W'(rq[0].row);
        req_col   = COL_W'(rq[0].col);
        req_flyby = rq[0].fb;
        wl        = WL_W'(rq[0].lead);
        if (idle_now) begin
          build(rq[0]);
          void'(rq.pop_front());
        end
      end else begin
        req_valid = 1'b0;
        req_bank  = '1;
        req_row   = '1;
        req_col   = '1;
        req_flyby = 1'b1;
        wl        = WL_W'(wl_noise);
      end
    end
  end

  task automatic send(int b, int r, int c, bit fb, int lead);
    req_t x;
    x.bank = b; x.row = r; x.col = c; x.fb = fb; x.lead = lead;
    rq.push_back(x);
  endtask

  task automatic drain();
    while (rq.size() > 0 || exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not complete, got hang exp completion");
    finish_run();
  end

  initial begin
    for (int b = 0; b < BANKS; b++) begin
      m_open[b] = 1'b0; m_row[b] = 0; m_fb[b] = 1'b0;
    end
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_flyby = 1'b0;
    req_bank  = '0;
    req_row   = '0;
    req_col   = '0;
    wl        = '0;
    repeat (3) @(negedge clk);
    compare(idle_vec(), "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    running = 1'b1;
    repeat (3) @(negedge clk);

    // R3, R2: closed bank, ordinary write
    cur_req = "R3 R2 R6";
    send(0, 12'h05a, 9'h017, 1'b0, 3);
    drain();

    // R4: same row, same mode
    cur_req = "R4 R6";
    send(0, 12'h05a, 9'h1f0, 1'b0, 1);
    drain();

    // R5: mode-only mismatch to fly-by, R7 R8 R6 on the reopen path
    cur_req = "R5 R7 R8 R6";
    send(0, 12'h05a, 9'h033, 1'b1, 1);
    drain();

    // R4 R8: fly-by hit for every lead value
    cur_req = "R4 R8 R7";
    for (int k = 0; k < 4; k++) begin
      send(0, 12'h05a, 9'h040 + k, 1'b1, k);
      drain();
    end

    // R3 R8: fly-by to closed banks and row misses, every lead value
    cur_req = "R3 R5 R8 R7";
    for (int k = 0; k < 4; k++) begin
      send(1, 12'h100 + k, 9'h011, 1'b1, k);
      drain();
    end

    // R5: ordinary write to a row opened for fly-by
    cur_req = "R5 R6";
    send(0, 12'h05a, 9'h002, 1'b0, 2);
    drain();

    // R11: bank independence
    cur_req = "R11";
    send(2, 12'h222, 9'h001, 1'b0, 0);
    drain();
    send(3, 12'h333, 9'h002, 1'b1, 2);
    drain();
    send(2, 12'h222, 9'h003, 1'b0, 0);
    drain();
    send(1, 12'h103, 9'h004, 1'b1, 3);
    drain();

    // R9: back-to-back requests held while busy
    cur_req = "R9";
    send(2, 12'h2a0, 9'h005, 1'b0, 0);
    send(2, 12'h2a0, 9'h006, 1'b1, 3);
    send(3, 12'h333, 9'h007, 1'b1, 0);
    send(3, 12'h333, 9'h008, 1'b1, 2);
    drain();

    // R10: lead and request pins change after acceptance
    cur_req = "R10";
    wl_noise = 3;
    send(1, 12'h0f0, 9'h009, 1'b1, 0);
    drain();
    wl_noise = 0;
    send(0, 12'h0f0, 9'h00a, 1'b1, 3);
    drain();

    repeat (3) @(negedge clk);
    running = 1'b0;
    finish_run();
  end

endmodule